// File: doc/BRIEF.md
# PHY auto-negotiation sequencer

This block brings an Ethernet PHY from an unknown configuration to a negotiated link without software involvement. A single `start` pulse makes it run a fixed series of management register accesses through an external MDIO master. It turns on auto-negotiation with every 10/100 ability advertised and restarts negotiation. It then polls the status register at a fixed interval until negotiation completes or the poll budget runs out. Once negotiation completes, it derives link, duplex and speed from the PHY's status and link-partner registers. The MDIO master is reached through a simple request/response handshake. A request is held with stable fields until a one-cycle response returns the read data and an acknowledge flag.

The state machine walks these states: `ST_IDLE` → `ST_CTL_RD` → `ST_CTL_WR` → `ST_ADV_RD` → `ST_ADV_WR` → `ST_RST_RD` → `ST_RST_WR` → `ST_WAIT` ⇄ `ST_POLL` → `ST_LINK_RD` → `ST_LPA_RD` → `ST_DONE`. A read state moves on when its response arrives with the acknowledge set. Every read state jumps to `ST_DONE` when its response arrives with the acknowledge clear. `ST_POLL` returns to `ST_WAIT` while negotiation is incomplete and polls remain. It jumps to `ST_DONE` on the last incomplete poll, and moves to `ST_LINK_RD` once negotiation is complete. `ST_LINK_RD` moves to `ST_LPA_RD` when the link bit is set and to `ST_DONE` otherwise. `ST_IDLE` and `ST_DONE` accept `start`.

Top module: `phy_autoneg_seq`

## Requirements
- R1: The cycle after `start` is accepted, a read request (write flag low) is issued for register 0 (basic control) at the PHY address captured with `start`.
- R2: Once that read is acknowledged, register 0 is written with the read value ORed with 0x3100 (bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex).
- R3: Register 4 (advertisement) is read next and written back ORed with 0x01E0 (bits 8, 7, 6, 5: 100-full, 100-half, 10-full, 10-half).
- R4: Register 0 is read again and written back ORed with 0x0200 (bit 9, restart negotiation).
- R5: Each read of register 1 (basic status) follows exactly `POLL_CYCLES` cycles with no request after the previous response. Requests that are not polls follow their predecessor's response with no idle cycle.
- R6: A poll with bit 5 set ends polling. Register 1 is then read once more, and its bit 2 is the link indication.
- R7: If `MAX_POLLS` polls all return bit 5 clear, `done` rises with `success` low and all results low.
- R8: A read response with the acknowledge low, at any step, ends the run: `done` is high and `success`, `link_up`, `full_duplex` and `speed_100` are all low. The acknowledge on write responses has no effect.
- R9: Register 5 (partner ability) is read only when the link bit is set. `full_duplex` = bit 8 OR bit 6. `speed_100` = bit 8 OR bit 7. With the link bit clear, the run ends with `success` high and all three results low.
- R10: `done` rises the cycle after the final response. It is held with all results until the next accepted `start`, which clears them the following cycle. A `start` during a run has no effect, and no request is issued while `done` is high.
- R11: A request keeps its fields stable until its response arrives.
- R12: During and after reset, `req_valid`, `done` and all results are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (accepted only when idle or done) |
| phy_addr | input | 5 | PHY address, captured with `start` |
| req_valid | output | 1 | Management access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | One-cycle response to the pending request |
| rsp_ack | input | 1 | PHY acknowledged the read |
| rsp_rdata | input | 16 | Read data |
| done | output | 1 | Run finished, held until next start |
| success | output | 1 | Run finished without error or timeout |
| link_up | output | 1 | Link established |
| full_duplex | output | 1 | Resolved full duplex |
| speed_100 | output | 1 | Resolved 100 Mb/s |

## Verification
A new request appears on the sample right after the response edge of the previous access, with no idle cycle. The one exception is a status poll, which appears after exactly `POLL_CYCLES` idle samples. The bench counts those idle samples before each request and compares them with the expected gap. `done` and the results are due on the sample that immediately follows the final response, and an accepted `start` clears them on the sample after the start edge. The bench's behavioural model updates its expected outputs at those exact points and compares all five outputs on every falling edge. As a result, an early or late update is caught on the cycle it happens.

// File: rtl/phy_an_pkg.sv
package phy_an_pkg;

    // Management register numbers (fixed by the MII register set)
    localparam logic [4:0] REG_BCTL = 5'd0;
    localparam logic [4:0] REG_BSTS = 5'd1;
    localparam logic [4:0] REG_ADVT = 5'd4;
    localparam logic [4:0] REG_PART = 5'd5;

    // Bits ORed into the control register on bring-up: speed 100, AN enable, full duplex
    localparam logic [15:0] CTL_BRINGUP = 16'h3100;
    // Restart-negotiation bit of the control register
    localparam logic [15:0] CTL_RENEG   = 16'h0200;
    // All four 10/100 abilities in the advertisement register
    localparam logic [15:0] ADV_ALL     = 16'h01E0;

    localparam int STS_LINK_BIT   = 2;
    localparam int STS_ANDONE_BIT = 5;
    localparam int ABL_10F_BIT    = 6;
    localparam int ABL_100H_BIT   = 7;
    localparam int ABL_100F_BIT   = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTL_RD,
        ST_CTL_WR,
        ST_ADV_RD,
        ST_ADV_WR,
        ST_RST_RD,
        ST_RST_WR,
        ST_WAIT,
        ST_POLL,
        ST_LINK_RD,
        ST_LPA_RD,
        ST_DONE
    } an_state_e;

endpackage

// File: rtl/an_interval_timer.sv
module an_interval_timer #(
    parameter int CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic run,
    output logic expire
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);

    // R5
    kick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !run);

endmodule

// File: rtl/an_poll_counter.sv
module an_poll_counter #(
    parameter int MAX_POLLS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == PW'(MAX_POLLS - 1));

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);

endmodule

// File: rtl/an_ability_resolve.sv
module an_ability_resolve
    import phy_an_pkg::*;
(
    input  logic [15:0] part,
    output logic        fd,
    output logic        s100
);
    always_comb begin
        fd   = part[ABL_100F_BIT] | part[ABL_10F_BIT];
        s100 = part[ABL_100F_BIT] | part[ABL_100H_BIT];
    end
endmodule

// File: rtl/phy_autoneg_seq.sv
module phy_autoneg_seq
    import phy_an_pkg::*;
#(
    parameter int POLL_CYCLES = 5_000_000,
    parameter int MAX_POLLS   = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  phy_addr,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_phy,
    output logic [4:0]  req_reg,
    output logic [15:0] req_wdata,
    input  logic        rsp_valid,
    input  logic        rsp_ack,
    input  logic [15:0] rsp_rdata,
    output logic        done,
    output logic        success,
    output logic        link_up,
    output logic        full_duplex,
    output logic        speed_100
);
    an_state_e   state_q, state_d;
    logic [4:0]  addr_q;
    logic [15:0] data_q;
    logic        done_q, success_q, link_q, fd_q, s100_q;

    logic launch, is_read, rd_nack;
    logic fin_ok, fin_bad;
    logic kick, step, expire, last;
    logic res_fd, res_s100;

    assign launch  = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start;
    assign rd_nack = rsp_valid && !rsp_ack && is_read;

    always_comb begin
        unique case (state_q)
            ST_CTL_RD, ST_ADV_RD, ST_RST_RD,
            ST_POLL, ST_LINK_RD, ST_LPA_RD: is_read = 1'b1;
            default:                        is_read = 1'b0;
        endcase
    end

    an_interval_timer #(.CYCLES(POLL_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (kick),
        .run    (state_q == ST_WAIT),
        .expire (expire)
    );

    an_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .step  (step),
        .last  (last)
    );

    an_ability_resolve u_resolve (
        .part (rsp_rdata),
        .fd   (res_fd),
        .s100 (res_s100)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fin_ok  = 1'b0;
        fin_bad = 1'b0;
        kick    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = ST_CTL_RD;
            end
            ST_CTL_RD: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    state_d = ST_CTL_WR;
                end
            end
            ST_CTL_WR: begin
                if (rsp_valid) state_d = ST_ADV_RD;
            end
            ST_ADV_RD: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    state_d = ST_ADV_WR;
                end
            end
            ST_ADV_WR: begin
                if (rsp_valid) state_d = ST_RST_RD;
            end
            ST_RST_RD: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    state_d = ST_RST_WR;
                end
            end
            ST_RST_WR: begin
                if (rsp_valid) begin
                    state_d = ST_WAIT;
                    kick    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (expire) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    if (rsp_rdata[STS_ANDONE_BIT]) begin
                        state_d = ST_LINK_RD;
                    end else if (last) begin
                        state_d = ST_DONE;
                        fin_bad = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                        kick    = 1'b1;
                        step    = 1'b1;
                    end
                end
            end
            ST_LINK_RD: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    if (rsp_rdata[STS_LINK_BIT]) begin
                        state_d = ST_LPA_RD;
                    end else begin
                        state_d = ST_DONE;
                        fin_ok  = 1'b1;
                    end
                end
            end
            ST_LPA_RD: begin
                if (rd_nack) begin
                    state_d = ST_DONE;
                    fin_bad = 1'b1;
                end else if (rsp_valid) begin
                    state_d = ST_DONE;
                    fin_ok  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered results and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            success_q <= 1'b0;
            link_q    <= 1'b0;
            fd_q      <= 1'b0;
            s100_q    <= 1'b0;
        end else if (launch) begin
            addr_q    <= phy_addr;
            done_q    <= 1'b0;
            success_q <= 1'b0;
            link_q    <= 1'b0;
            fd_q      <= 1'b0;
            s100_q    <= 1'b0;
        end else begin
            if (rsp_valid && rsp_ack && is_read) data_q <= rsp_rdata;
            if (fin_bad) begin
                done_q    <= 1'b1;
                success_q <= 1'b0;
                link_q    <= 1'b0;
                fd_q      <= 1'b0;
                s100_q    <= 1'b0;
            end else if (fin_ok) begin
                done_q    <= 1'b1;
                success_q <= 1'b1;
                if (state_q == ST_LPA_RD) begin
                    link_q <= 1'b1;
                    fd_q   <= res_fd;
                    s100_q <= res_s100;
                end
            end
        end
    end

    // Request decode
    always_comb begin
        req_valid = 1'b1;
        req_write = 1'b0;
        req_reg   = REG_BCTL;
        req_wdata = '0;
        unique case (state_q)
            ST_CTL_RD:  req_reg = REG_BCTL;
            ST_CTL_WR: begin
                req_write = 1'b1;
                req_wdata = data_q | CTL_BRINGUP;
            end
            ST_ADV_RD:  req_reg = REG_ADVT;
            ST_ADV_WR: begin
                req_write = 1'b1;
                req_reg   = REG_ADVT;
                req_wdata = data_q | ADV_ALL;
            end
            ST_RST_RD:  req_reg = REG_BCTL;
            ST_RST_WR: begin
                req_write = 1'b1;
                req_wdata = data_q | CTL_RENEG;
            end
            ST_POLL, ST_LINK_RD: req_reg = REG_BSTS;
            ST_LPA_RD:  req_reg = REG_PART;
            default:    req_valid = 1'b0;
        endcase
    end

    assign req_phy     = addr_q;
    assign done        = done_q;
    assign success     = success_q;
    assign link_up     = link_q;
    assign full_duplex = fd_q;
    assign speed_100   = s100_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_write) && $stable(req_reg)
                                       && $stable(req_wdata) && $stable(req_phy)));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(success) && $stable(link_up)
                              && $stable(full_duplex) && $stable(speed_100)));

    // R10
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    // R9
    ability_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex || speed_100) |-> link_up);

    // R6
    link_needs_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (done && success));

    // R8
    success_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> done);

endmodule

// File: tb/phy_autoneg_seq_bench.sv
module phy_autoneg_seq_bench;
    localparam int CLK_NS = 10;
    localparam int POLL   = 12;
    localparam int NPOLL  = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [4:0]  phy_addr;
    logic        req_valid, req_write;
    logic [4:0]  req_phy, req_reg;
    logic [15:0] req_wdata;
    logic        rsp_valid, rsp_ack;
    logic [15:0] rsp_rdata;
    logic        done, success, link_up, full_duplex, speed_100;

    always #(CLK_NS/2) clk = ~clk;

    phy_autoneg_seq #(.POLL_CYCLES(POLL), .MAX_POLLS(NPOLL)) u_phy_autoneg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .done(done), .success(success), .link_up(link_up),
        .full_duplex(full_duplex), .speed_100(speed_100)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic e_done, e_succ, e_link, e_fd, e_s100;
    logic p_succ, p_link, p_fd, p_s100;
    logic [4:0] cur_addr;

    task automatic note(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock; outputs compared against the model on every falling edge
    task automatic tick();
        @(negedge clk);
        note(done === e_done, "R10", "done", done, e_done);
        note(success === e_succ, "R8", "success", success, e_succ);
        note(link_up === e_link, "R6", "link_up", link_up, e_link);
        note(full_duplex === e_fd, "R9", "full_duplex", full_duplex, e_fd);
        note(speed_100 === e_s100, "R9", "speed_100", speed_100, e_s100);
        if (e_done || !rst_n)
            note(req_valid === 1'b0, e_done ? "R10" : "R12", "req_valid", req_valid, 0);
    endtask

    task automatic serve(input bit wr, input logic [4:0] rg, input logic [15:0] wd,
                         input int gap_exp, input bit ack, input logic [15:0] rd,
                         input int dly, input bit fin, input string tag);
        int gap = 0;
        while (req_valid !== 1'b1 && gap < POLL + 40) begin
            tick();
            gap++;
        end
        note(gap == gap_exp, (gap_exp == POLL) ? "R5" : tag, "idle cycles before request", gap, gap_exp);
        note(req_write === wr, tag, "write flag", req_write, wr);
        note(req_reg === rg, tag, "register", req_reg, rg);
        note(req_phy === cur_addr, tag, "phy address", req_phy, cur_addr);
        if (wr) note(req_wdata === wd, tag, "write data", req_wdata, wd);
        repeat (dly) tick();
        note(req_valid === 1'b1 && req_reg === rg && req_write === wr, "R11",
             "request held", {req_valid, req_write, req_reg}, {1'b1, wr, rg});
        rsp_valid = 1'b1;
        rsp_ack   = ack;
        rsp_rdata = rd;
        if (fin) begin
            e_done = 1'b1; e_succ = p_succ; e_link = p_link; e_fd = p_fd; e_s100 = p_s100;
        end
        tick();
        rsp_valid = 1'b0;
        rsp_ack   = 1'b0;
        rsp_rdata = '0;
    endtask

    // nack_at: 0 none, 1 ctl read, 2 adv read, 3 ctl re-read, 4 first poll, 5 link read, 6 partner read
    task automatic run_an(input logic [4:0] a, input logic [15:0] c0, input logic [15:0] adv0,
                          input logic [15:0] c2, input int ok_poll, input int nack_at,
                          input bit wr_ack, input bit lnk, input logic [15:0] lpa,
                          input int dly, input bit poke);
        cur_addr = a;
        phy_addr = a;
        start    = 1'b1;
        e_done = 1'b0; e_succ = 1'b0; e_link = 1'b0; e_fd = 1'b0; e_s100 = 1'b0;
        tick();
        start = 1'b0;
        p_succ = 1'b0; p_link = 1'b0; p_fd = 1'b0; p_s100 = 1'b0;

        serve(1'b0, 5'd0, 16'h0, 0, nack_at != 1, c0, dly, nack_at == 1, (nack_at == 1) ? "R8" : "R1");
        if (nack_at == 1) begin repeat (6) tick(); return; end
        serve(1'b1, 5'd0, c0 | 16'h3100, 0, wr_ack, 16'h0, dly, 1'b0, "R2");
        serve(1'b0, 5'd4, 16'h0, 0, nack_at != 2, adv0, dly, nack_at == 2, (nack_at == 2) ? "R8" : "R3");
        if (nack_at == 2) begin repeat (6) tick(); return; end
        if (poke) begin
            // R10: start during a run is ignored; address must not change
            phy_addr = ~a;
            start    = 1'b1;
            tick();
            start    = 1'b0;
            phy_addr = a;
        end
        serve(1'b1, 5'd4, adv0 | 16'h01E0, 0, wr_ack, 16'h0, dly, 1'b0, "R3");
        serve(1'b0, 5'd0, 16'h0, 0, nack_at != 3, c2, dly, nack_at == 3, (nack_at == 3) ? "R8" : "R4");
        if (nack_at == 3) begin repeat (6) tick(); return; end
        serve(1'b1, 5'd0, c2 | 16'h0200, 0, wr_ack, 16'h0, dly, 1'b0, "R4");

        for (int k = 1; k <= NPOLL; k++) begin
            bit hit = (k == ok_poll);
            bit nk  = (nack_at == 4) && (k == 1);
            bit tmo = (k == NPOLL) && (ok_poll == 0);
            serve(1'b0, 5'd1, 16'h0, POLL, !nk, hit ? 16'h7829 : 16'h7809, dly, nk || tmo,
                  nk ? "R8" : (tmo ? "R7" : "R5"));
            if (nk || tmo) begin repeat (6) tick(); return; end
            if (hit) break;
        end

        p_succ = (nack_at != 5) && !lnk;
        serve(1'b0, 5'd1, 16'h0, 0, nack_at != 5, lnk ? 16'h782D : 16'h7829, dly,
              (nack_at == 5) || !lnk, (nack_at == 5) ? "R8" : "R6");
        if ((nack_at == 5) || !lnk) begin repeat (6) tick(); return; end

        if (nack_at != 6) begin
            p_succ = 1'b1;
            p_link = 1'b1;
            p_fd   = lpa[8] | lpa[6];
            p_s100 = lpa[8] | lpa[7];
        end
        serve(1'b0, 5'd5, 16'h0, 0, nack_at != 6, lpa, dly, 1'b1, (nack_at == 6) ? "R8" : "R9");
        repeat (6) tick();
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; phy_addr = '0;
        rsp_valid = 1'b0; rsp_ack = 1'b0; rsp_rdata = '0;
        e_done = 1'b0; e_succ = 1'b0; e_link = 1'b0; e_fd = 1'b0; e_s100 = 1'b0;
        cur_addr = '0;
        repeat (3) tick();   // R12 reset state
        rst_n = 1'b1;
        tick();

        // full 100 full duplex link, first poll completes
        run_an(5'h01, 16'h0000, 16'h0001, 16'h3100, 1, 0, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        // 10 full only, completes on last allowed poll, start poked mid-run
        run_an(5'h1F, 16'h0040, 16'h0C01, 16'h3140, NPOLL, 0, 1'b1, 1'b1, 16'h0041, 3, 1'b1);
        // 100 half, write acks low (R8: ignored)
        run_an(5'h0A, 16'h1000, 16'h0000, 16'h1000, 2, 0, 1'b0, 1'b1, 16'h0081, 2, 1'b0);
        // 10 half only
        run_an(5'h12, 16'h0000, 16'h01E1, 16'h3100, 1, 0, 1'b1, 1'b1, 16'h0021, 0, 1'b0);
        // negotiation complete but no link: no partner read (R9)
        run_an(5'h03, 16'h0000, 16'h0001, 16'h3100, 2, 0, 1'b1, 1'b0, 16'h01E1, 1, 1'b0);
        // R7 timeout
        run_an(5'h07, 16'h0000, 16'h0001, 16'h3100, 0, 0, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        // R8 read nacks at several steps
        run_an(5'h04, 16'h0000, 16'h0001, 16'h3100, 1, 1, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        run_an(5'h05, 16'h0000, 16'h0001, 16'h3100, 1, 2, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        run_an(5'h06, 16'h0000, 16'h0001, 16'h3100, 1, 3, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        run_an(5'h08, 16'h0000, 16'h0001, 16'h3100, 1, 4, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        run_an(5'h09, 16'h0000, 16'h0001, 16'h3100, 1, 5, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        run_an(5'h0B, 16'h0000, 16'h0001, 16'h3100, 1, 6, 1'b1, 1'b1, 16'h01E1, 1, 1'b0);
        // a good run after a failed one clears everything first
        run_an(5'h10, 16'h2000, 16'h0101, 16'h3100, 1, 0, 1'b1, 1'b1, 16'h0101, 1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule